// File: doc/BRIEF.md
# Answer-To-Reset and Character Timeout Monitor

This block watches the timing of a smart card's answer to reset and of the character stream that follows it. When the card's reset line is released, it counts card clock ticks until the first start bit arrives. From that first character on, it counts elementary time units (etus) until the answer to reset is reported complete. It also times the gap between the leading edges of consecutive characters, and it keeps timing that gap after the answer to reset has ended.

Each of the three limits has its own sticky timeout flag. A flag stays set until software clears it. The limits are plain inputs, so the interval limit can be changed once the protocol type is known. Decoding of the answer-to-reset contents is left to other logic.

Top module: `atr_watchdog`

## Requirements
- R1: After `card_reset` is seen low, counting starts on the following cycle. If `lim_first` card clock ticks (`cclk_tick`) are counted before any `char_start`, `tmo_first` is 1 in the cycle after the tick that reaches the limit, and not before.
- R2: The first `char_start` after release stops the start-of-answer count. Further `cclk_tick` pulses then never set `tmo_first`.
- R3: The first `char_start` begins the answer-duration count. `tmo_atr` is 1 in the cycle after the `lim_atr`-th `etu_tick` following that character, unless `atr_end` came first.
- R4: An `atr_end` pulse during the answer stops the duration count. Later `etu_tick` pulses never set `tmo_atr`.
- R5: Every `char_start` restarts the interval count from zero. A tick in the same cycle as `char_start` is not counted. `tmo_gap` is set after `lim_gap` `etu_tick` pulses without a new `char_start`.
- R6: The interval limit still applies to characters that arrive after `atr_end`.
- R7: Each timeout flag stays at 1 until `clr_flags` is pulsed. If a timeout and a clear happen in the same cycle, the flag is set.
- R8: Asserting `card_reset` again zeroes all three counts. After the next release, timing starts again from zero.
- R9: While `card_reset` is high, ticks and character strobes are ignored and no flag is set.
- R10: If the first character arrives after `tmo_first` has already been set, that character still starts the answer-duration count and the interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_reset | input | 1 | 1 while the card is held in reset |
| cclk_tick | input | 1 | One-cycle pulse per card clock period |
| etu_tick | input | 1 | One-cycle pulse per etu |
| char_start | input | 1 | Leading edge of a character's start bit |
| atr_end | input | 1 | Answer to reset fully received |
| clr_flags | input | 1 | Clears all three timeout flags |
| lim_first | input | 16 | Card clock limit for the first character |
| lim_atr | input | 16 | Etu limit for the whole answer to reset |
| lim_gap | input | 16 | Etu limit between character leading edges |
| tmo_first | output | 1 | Start-of-answer timeout flag |
| tmo_atr | output | 1 | Answer-duration timeout flag |
| tmo_gap | output | 1 | Character-interval timeout flag |

## Verification
The bench sets each limit to a small value and checks the flag one tick before the limit and on the tick that reaches it. A counter that is off by one would raise its flag a tick early or a tick late. Character strobes are sent just inside the interval limit to confirm that each one restarts the count. A design that did not reload would report a false timeout. `atr_end` and the first character are each checked to stop their own counter, and a stuck counter would set a flag late in the test. The bench also reasserts the card reset partway through a count, which exposes counts carried over from before the reset. Last, it checks that a first character arriving after the start timeout still starts the answer-duration timer.

// File: rtl/atr_wd_pkg.sv
package atr_wd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_ATR  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  localparam int unsigned N_TMO   = 3;
  localparam int unsigned IX_FRST = 0;
  localparam int unsigned IX_ATR  = 1;
  localparam int unsigned IX_GAP  = 2;
endpackage

// File: rtl/atr_wd_timer.sv
module atr_wd_timer #(
  parameter int unsigned LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             halt,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  localparam int unsigned EXT_W = LIM_W + 1;

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);

  // halt wins over arm, arm wins over counting
  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    if (halt) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (arm) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (cnt_inc >= {1'b0, limit}) begin
        expire = 1'b1;
        run_d  = 1'b0;
      end else begin
        cnt_d = cnt_inc[LIM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/atr_wd_seq.sv
module atr_wd_seq
  import atr_wd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic card_reset,
  input  logic char_start,
  input  logic atr_end,
  output logic frst_arm,
  output logic frst_halt,
  output logic atr_arm,
  output logic atr_halt,
  output logic gap_arm,
  output logic gap_halt
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (card_reset) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: ph_d = PH_WAIT;
        PH_WAIT: if (char_start) ph_d = PH_ATR;
        PH_ATR:  if (atr_end)    ph_d = PH_DATA;
        PH_DATA: ph_d = PH_DATA;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    frst_arm  = !card_reset && (ph_q == PH_IDLE);
    frst_halt = card_reset || ((ph_q == PH_WAIT) && char_start);
    atr_arm   = !card_reset && (ph_q == PH_WAIT) && char_start;
    atr_halt  = card_reset || ((ph_q == PH_ATR) && atr_end);
    gap_arm   = !card_reset && (ph_q != PH_IDLE) && char_start;
    gap_halt  = card_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/atr_watchdog.sv
module atr_watchdog
  import atr_wd_pkg::*;
#(
  parameter int unsigned LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_reset,
  input  logic             cclk_tick,
  input  logic             etu_tick,
  input  logic             char_start,
  input  logic             atr_end,
  input  logic             clr_flags,
  input  logic [LIM_W-1:0] lim_first,
  input  logic [LIM_W-1:0] lim_atr,
  input  logic [LIM_W-1:0] lim_gap,
  output logic             tmo_first,
  output logic             tmo_atr,
  output logic             tmo_gap
);
  logic frst_arm, frst_halt, atr_arm, atr_halt, gap_arm, gap_halt;
  logic [N_TMO-1:0] expire;
  logic [N_TMO-1:0] flag_q, flag_d;

  atr_wd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_reset (card_reset),
    .char_start (char_start),
    .atr_end    (atr_end),
    .frst_arm   (frst_arm),
    .frst_halt  (frst_halt),
    .atr_arm    (atr_arm),
    .atr_halt   (atr_halt),
    .gap_arm    (gap_arm),
    .gap_halt   (gap_halt)
  );

  atr_wd_timer #(.LIM_W(LIM_W)) u_tmr_first (
    .clk(clk), .rst_n(rst_n), .arm(frst_arm), .halt(frst_halt),
    .tick(cclk_tick), .limit(lim_first), .expire(expire[IX_FRST])
  );

  atr_wd_timer #(.LIM_W(LIM_W)) u_tmr_atr (
    .clk(clk), .rst_n(rst_n), .arm(atr_arm), .halt(atr_halt),
    .tick(etu_tick), .limit(lim_atr), .expire(expire[IX_ATR])
  );

  atr_wd_timer #(.LIM_W(LIM_W)) u_tmr_gap (
    .clk(clk), .rst_n(rst_n), .arm(gap_arm), .halt(gap_halt),
    .tick(etu_tick), .limit(lim_gap), .expire(expire[IX_GAP])
  );

  // sticky flags: a new timeout wins over a clear in the same cycle
  for (genvar g = 0; g < N_TMO; g++) begin : g_flag
    always_comb flag_d[g] = expire[g] | (flag_q[g] & ~clr_flags);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end
  end

  assign tmo_first = flag_q[IX_FRST];
  assign tmo_atr   = flag_q[IX_ATR];
  assign tmo_gap   = flag_q[IX_GAP];
endmodule

// File: rtl/atr_watchdog_chk.sv
module atr_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic card_reset,
  input logic cclk_tick,
  input logic etu_tick,
  input logic char_start,
  input logic atr_end,
  input logic clr_flags,
  input logic tmo_first,
  input logic tmo_atr,
  input logic tmo_gap
);
  a_r1_first_needs_cclk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_first) |-> $past(cclk_tick));

  a_r3_atr_needs_etu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_atr) |-> $past(etu_tick));

  a_r4_no_atr_tmo_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_atr) |-> !$past(atr_end));

  a_r5_gap_not_on_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_gap) |-> ($past(etu_tick) && !$past(char_start)));

  a_r7_sticky_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_first && !clr_flags) |=> tmo_first);

  a_r7_sticky_atr: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_atr && !clr_flags) |=> tmo_atr);

  a_r7_sticky_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_gap && !clr_flags) |=> tmo_gap);

  a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    card_reset |=> !($rose(tmo_first) || $rose(tmo_atr) || $rose(tmo_gap)));
endmodule

bind atr_watchdog atr_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .card_reset(card_reset), .cclk_tick(cclk_tick),
  .etu_tick(etu_tick), .char_start(char_start), .atr_end(atr_end),
  .clr_flags(clr_flags), .tmo_first(tmo_first), .tmo_atr(tmo_atr),
  .tmo_gap(tmo_gap)
);

// File: tb/test_atr_watchdog.sv
`timescale 1ns/1ps
module test_atr_watchdog;
  logic clk = 1'b0;
  logic rst_n;
  logic card_reset, cclk_tick, etu_tick, char_start, atr_end, clr_flags;
  logic [15:0] lim_first, lim_atr, lim_gap;
  logic tmo_first, tmo_atr, tmo_gap;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  atr_watchdog i_atr_watchdog (
    .clk(clk), .rst_n(rst_n), .card_reset(card_reset), .cclk_tick(cclk_tick),
    .etu_tick(etu_tick), .char_start(char_start), .atr_end(atr_end),
    .clr_flags(clr_flags), .lim_first(lim_first), .lim_atr(lim_atr),
    .lim_gap(lim_gap), .tmo_first(tmo_first), .tmo_atr(tmo_atr),
    .tmo_gap(tmo_gap)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cticks(input int n);
    for (int i = 0; i < n; i++) begin
      cclk_tick = 1'b1; step(1); cclk_tick = 1'b0;
    end
  endtask

  task automatic eticks(input int n);
    for (int i = 0; i < n; i++) begin
      etu_tick = 1'b1; step(1); etu_tick = 1'b0;
    end
  endtask

  task automatic pulse_char();
    char_start = 1'b1; step(1); char_start = 1'b0;
  endtask

  task automatic pulse_end();
    atr_end = 1'b1; step(1); atr_end = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_flags = 1'b1; step(1); clr_flags = 1'b0;
  endtask

  // hold card in reset, clear flags, release; counting begins next cycle
  task automatic card_cycle();
    card_reset = 1'b1; step(1);
    pulse_clr();
    card_reset = 1'b0; step(1);
  endtask

  task automatic t_reset_state();
    chk("R9 reset first", tmo_first, 1'b0);
    chk("R9 reset atr", tmo_atr, 1'b0);
    chk("R9 reset gap", tmo_gap, 1'b0);
  endtask

  task automatic t_first_timeout();
    lim_first = 16'd5; card_cycle();
    cticks(4);
    chk("R1 before limit", tmo_first, 1'b0);
    cticks(1);
    chk("R1 at limit", tmo_first, 1'b1);
  endtask

  task automatic t_first_met();
    lim_first = 16'd5; lim_atr = 16'd1000; lim_gap = 16'd1000; card_cycle();
    cticks(4);
    pulse_char();
    cticks(10);
    chk("R2 stopped by char", tmo_first, 1'b0);
  endtask

  task automatic t_atr_timeout();
    lim_first = 16'd100; lim_atr = 16'd6; lim_gap = 16'd1000; card_cycle();
    cticks(2);
    pulse_char();
    eticks(5);
    chk("R3 before limit", tmo_atr, 1'b0);
    eticks(1);
    chk("R3 at limit", tmo_atr, 1'b1);
  endtask

  task automatic t_atr_end();
    lim_atr = 16'd6; lim_gap = 16'd1000; card_cycle();
    pulse_char();
    eticks(3);
    pulse_end();
    eticks(10);
    chk("R4 stopped by end", tmo_atr, 1'b0);
  endtask

  task automatic t_gap();
    lim_atr = 16'd1000; lim_gap = 16'd4; card_cycle();
    pulse_char(); eticks(3);
    pulse_char(); eticks(3);
    pulse_char(); eticks(3);
    chk("R5 reload keeps quiet", tmo_gap, 1'b0);
    // tick coincident with char_start is not counted
    etu_tick = 1'b1; char_start = 1'b1; step(1);
    etu_tick = 1'b0; char_start = 1'b0;
    eticks(3);
    chk("R5 same-cycle tick ignored", tmo_gap, 1'b0);
    eticks(1);
    chk("R5 gap limit", tmo_gap, 1'b1);
    // after the answer
    pulse_end();
    pulse_clr();
    pulse_char(); eticks(3);
    chk("R6 post-atr before limit", tmo_gap, 1'b0);
    eticks(1);
    chk("R6 post-atr at limit", tmo_gap, 1'b1);
  endtask

  task automatic t_sticky();
    lim_first = 16'd2; card_cycle();
    cticks(2);
    chk("R7 set", tmo_first, 1'b1);
    cticks(5); step(3);
    chk("R7 stays", tmo_first, 1'b1);
    pulse_clr();
    chk("R7 cleared", tmo_first, 1'b0);
    // set and clear together: set wins
    lim_first = 16'd1; card_cycle();
    clr_flags = 1'b1; cclk_tick = 1'b1; step(1);
    clr_flags = 1'b0; cclk_tick = 1'b0;
    chk("R7 set beats clear", tmo_first, 1'b1);
  endtask

  task automatic t_rearm();
    lim_first = 16'd5; card_cycle();
    cticks(3);
    card_reset = 1'b1; step(2);
    card_reset = 1'b0; step(1);
    cticks(4);
    chk("R8 count restarted", tmo_first, 1'b0);
    cticks(1);
    chk("R8 limit after restart", tmo_first, 1'b1);
  endtask

  task automatic t_in_reset();
    lim_first = 16'd1; lim_atr = 16'd1; lim_gap = 16'd1;
    card_reset = 1'b1; step(1); pulse_clr();
    for (int i = 0; i < 6; i++) begin
      cclk_tick = 1'b1; etu_tick = 1'b1; char_start = (i == 2); step(1);
    end
    cclk_tick = 1'b0; etu_tick = 1'b0; char_start = 1'b0;
    chk("R9 first quiet", tmo_first, 1'b0);
    chk("R9 atr quiet", tmo_atr, 1'b0);
    chk("R9 gap quiet", tmo_gap, 1'b0);
    card_reset = 1'b0; step(1);
  endtask

  task automatic t_late_char();
    lim_first = 16'd3; lim_atr = 16'd4; lim_gap = 16'd1000; card_cycle();
    cticks(3);
    chk("R10 start timed out", tmo_first, 1'b1);
    pulse_char();
    eticks(3);
    chk("R10 atr before limit", tmo_atr, 1'b0);
    eticks(1);
    chk("R10 atr at limit", tmo_atr, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; card_reset = 1'b1;
    cclk_tick = 1'b0; etu_tick = 1'b0; char_start = 1'b0;
    atr_end = 1'b0; clr_flags = 1'b0;
    lim_first = 16'd40000; lim_atr = 16'd19200; lim_gap = 16'd9600;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset_state();
    t_first_timeout();
    t_first_met();
    t_atr_timeout();
    t_atr_end();
    t_gap();
    t_sticky();
    t_rearm();
    t_in_reset();
    t_late_char();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule